// File: doc/BRIEF.md
# Nibble/Byte Accumulator Processor Core

This block is a very small accumulator machine for designs with a tight gate budget. It puts a 7-bit program counter on an address bus and takes back an 8-bit instruction word in the same cycle from an external, combinationally read program store. Every word takes one clock. The core holds one accumulator, a few data words in flip-flops and a registered output port that outside logic can watch. An input port can be copied into the accumulator.

The parameter `DATA_W` picks the variant. With 4 the core has a nibble datapath and eight data words. With 8 the datapath is a byte, there are four data words, and one more instruction is enabled. That instruction takes the following program word as an 8-bit literal for the accumulator.

Arithmetic is limited to addition, NAND and exclusive-OR of the accumulator with a data word. A conditional branch on a zero accumulator is the only control transfer.

Top module: `acc_core`

## Requirements
- R1: While `rst` is high at a rising edge, the program counter, the accumulator and `out_port_o` become zero and any pending byte load is cancelled. Data words are not cleared.
- R2: `imem_addr_o` shows the program counter. Each cycle it advances by one, modulo 128, unless a taken branch loads it.
- R3: `0000_aaaa` copies data word `a` into the accumulator and `0001_aaaa` writes the accumulator into word `a`. Only the low 3 bits of `aaaa` (DATA_W=4) or the low 2 bits (DATA_W=8) select the word.
- R4: `0010_iiii` loads the accumulator with `iiii`, zero-extended to the datapath width.
- R5: `0011_aaaa` adds word `a` to the accumulator modulo 2^DATA_W. `0100_aaaa` puts the NAND of the two in the accumulator and `0101_aaaa` their exclusive-OR.
- R6: `0110_xxx0` copies the accumulator to `out_port_o` and `0110_xxx1` copies `in_port_i` into the accumulator. `out_port_o` holds its value at every other time.
- R7: `1ttt_tttt` loads the program counter with `ttttttt` when the accumulator is zero and otherwise falls through to the next word.
- R8: With DATA_W=8, `0111_xxxx` makes the next program word an 8-bit literal that is written to the accumulator and is not executed. With DATA_W=4 the word `0111_xxxx` changes nothing.
- R9: DATA_W=4 gives eight nibble data words and DATA_W=8 gives four byte words. Addresses beyond the depth alias onto the lower words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every state change happens on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| imem_addr_o | output | 7 | Program counter, used as the program store address |
| imem_data_i | input | 8 | Instruction word at `imem_addr_o`, same cycle |
| in_port_i | input | DATA_W | Value that the input instruction copies into the accumulator |
| out_port_o | output | DATA_W | Registered output port |

## Verification
The accumulator is not a port. A wrong accumulator value shows up in one of two ways. It appears on `out_port_o` one edge after the next output instruction. It also changes the path of the next zero-test branch, which shows on `imem_addr_o` one edge after that branch. A bad data word stays hidden until it is loaded or used in arithmetic, and then it reaches the ports by the same two paths. The programs therefore place output instructions and zero tests close after each operation. A decode error in a program counter update, such as a missing wrap, a wrong target or a skipped literal word, shows on the address port at the very next edge.

// File: rtl/acc_core_pkg.sv
package acc_core_pkg;

  localparam int PC_W    = 7;
  localparam int INSTR_W = 8;
  localparam int IMM_W   = 4;

  typedef logic [PC_W-1:0]    pc_t;
  typedef logic [INSTR_W-1:0] instr_t;

  // bits [6:4] of a word whose bit 7 is clear
  typedef enum logic [2:0] {
    OP_LDM  = 3'd0,
    OP_STM  = 3'd1,
    OP_LDI  = 3'd2,
    OP_ADD  = 3'd3,
    OP_NAND = 3'd4,
    OP_XOR  = 3'd5,
    OP_IO   = 3'd6,
    OP_LDB  = 3'd7
  } op_e;

  typedef enum logic [1:0] {
    ALU_ADD  = 2'd0,
    ALU_NAND = 2'd1,
    ALU_XOR  = 2'd2
  } alu_fn_e;

  typedef enum logic [2:0] {
    ACC_HOLD = 3'd0,
    ACC_MEM  = 3'd1,
    ACC_IMM  = 3'd2,
    ACC_ALU  = 3'd3,
    ACC_IN   = 3'd4,
    ACC_BYTE = 3'd5
  } acc_src_e;

  typedef struct packed {
    acc_src_e acc_src;
    alu_fn_e  alu_fn;
    logic     mem_we;
    logic     out_we;
    logic     is_branch;
    logic     is_in;
    logic     ldb_start;
  } ctl_t;

  function automatic logic word_is_branch(instr_t w);
    return w[INSTR_W-1];
  endfunction

  function automatic op_e word_op(instr_t w);
    return op_e'(w[6:4]);
  endfunction

  function automatic pc_t word_target(instr_t w);
    return w[PC_W-1:0];
  endfunction

  function automatic logic [IMM_W-1:0] word_field(instr_t w);
    return w[IMM_W-1:0];
  endfunction

endpackage

// File: rtl/acc_core_decode.sv
module acc_core_decode
  import acc_core_pkg::*;
#(
  parameter bit HAS_LDB = 1'b0
) (
  input  instr_t instr_i,
  input  logic   ldb_pend_i,
  output ctl_t   ctl_o
);

  always_comb begin
    ctl_o         = '0;
    ctl_o.acc_src = ACC_HOLD;
    ctl_o.alu_fn  = ALU_ADD;
    if (ldb_pend_i) begin
      // literal word of a byte load: never executed as an instruction
      ctl_o.acc_src = ACC_BYTE;
    end else if (word_is_branch(instr_i)) begin
      ctl_o.is_branch = 1'b1;
    end else begin
      unique case (word_op(instr_i))
        OP_LDM:  ctl_o.acc_src = ACC_MEM;
        OP_STM:  ctl_o.mem_we  = 1'b1;
        OP_LDI:  ctl_o.acc_src = ACC_IMM;
        OP_ADD: begin
          ctl_o.acc_src = ACC_ALU;
          ctl_o.alu_fn  = ALU_ADD;
        end
        OP_NAND: begin
          ctl_o.acc_src = ACC_ALU;
          ctl_o.alu_fn  = ALU_NAND;
        end
        OP_XOR: begin
          ctl_o.acc_src = ACC_ALU;
          ctl_o.alu_fn  = ALU_XOR;
        end
        OP_IO: begin
          if (instr_i[0]) begin
            ctl_o.acc_src = ACC_IN;
            ctl_o.is_in   = 1'b1;
          end else begin
            ctl_o.out_we = 1'b1;
          end
        end
        OP_LDB:  ctl_o.ldb_start = HAS_LDB;
      endcase
    end
  end

endmodule

// File: rtl/acc_core_alu.sv
module acc_core_alu
  import acc_core_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  alu_fn_e      fn_i,
  output logic [W-1:0] y_o
);

  function automatic logic [W-1:0] f_add(logic [W-1:0] a, logic [W-1:0] b);
    return a + b;
  endfunction

  function automatic logic [W-1:0] f_nand(logic [W-1:0] a, logic [W-1:0] b);
    return ~(a & b);
  endfunction

  function automatic logic [W-1:0] f_xor(logic [W-1:0] a, logic [W-1:0] b);
    return a ^ b;
  endfunction

  always_comb begin
    unique case (fn_i)
      ALU_ADD:  y_o = f_add(a_i, b_i);
      ALU_NAND: y_o = f_nand(a_i, b_i);
      ALU_XOR:  y_o = f_xor(a_i, b_i);
      default:  y_o = a_i;
    endcase
  end

endmodule

// File: rtl/acc_core_dmem.sv
module acc_core_dmem #(
  parameter  int W     = 4,
  parameter  int DEPTH = 8,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [W-1:0]  wdata_i,
  output logic [W-1:0]  rdata_o
);

  logic [DEPTH-1:0][W-1:0] words;

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    logic [W-1:0] word_q;
    always_ff @(posedge clk) begin
      if (we_i && (addr_i == AW'(g))) begin
        word_q <= wdata_i;
      end
    end
    assign words[g] = word_q;
  end

  assign rdata_o = words[addr_i];

endmodule

// File: rtl/acc_core_pc.sv
module acc_core_pc
  import acc_core_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic take_i,
  input  pc_t  target_i,
  output pc_t  pc_o
);

  pc_t pc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q <= '0;
    end else if (take_i) begin
      pc_q <= target_i;
    end else begin
      pc_q <= pc_q + pc_t'(1);
    end
  end

  assign pc_o = pc_q;

endmodule

// File: rtl/acc_core.sv
module acc_core
  import acc_core_pkg::*;
#(
  parameter  int DATA_W  = 4,
  localparam int DEPTH   = (DATA_W == 8) ? 4 : 8,
  localparam int AW      = $clog2(DEPTH),
  localparam bit HAS_LDB = (DATA_W == 8)
) (
  input  logic              clk,
  input  logic              rst,
  output logic [PC_W-1:0]   imem_addr_o,
  input  logic [INSTR_W-1:0] imem_data_i,
  input  logic [DATA_W-1:0] in_port_i,
  output logic [DATA_W-1:0] out_port_o
);

  ctl_t              ctl;
  logic [DATA_W-1:0] acc_q;
  logic [DATA_W-1:0] acc_d;
  logic [DATA_W-1:0] out_q;
  logic              ldb_pend_q;
  logic [DATA_W-1:0] mem_rdata;
  logic [DATA_W-1:0] alu_y;
  logic [DATA_W-1:0] imm_nibble;
  logic [DATA_W-1:0] imm_byte;
  logic [AW-1:0]     mem_addr;
  logic              acc_zero;
  logic              branch_taken;
  logic              out_we;
  logic              is_in;
  pc_t               pc;

  // named events for the checker
  assign out_we       = ctl.out_we;
  assign is_in        = ctl.is_in;
  assign acc_zero     = (acc_q == '0);
  assign branch_taken = ctl.is_branch & acc_zero;

  assign mem_addr   = imem_data_i[AW-1:0];
  assign imm_nibble = DATA_W'(word_field(imem_data_i));
  assign imm_byte   = imem_data_i[DATA_W-1:0];

  acc_core_decode #(
    .HAS_LDB (HAS_LDB)
  ) u_decode (
    .instr_i    (imem_data_i),
    .ldb_pend_i (ldb_pend_q),
    .ctl_o      (ctl)
  );

  acc_core_pc u_pc (
    .clk      (clk),
    .rst      (rst),
    .take_i   (branch_taken),
    .target_i (word_target(imem_data_i)),
    .pc_o     (pc)
  );

  acc_core_dmem #(
    .W     (DATA_W),
    .DEPTH (DEPTH)
  ) u_dmem (
    .clk     (clk),
    .we_i    (ctl.mem_we),
    .addr_i  (mem_addr),
    .wdata_i (acc_q),
    .rdata_o (mem_rdata)
  );

  acc_core_alu #(
    .W (DATA_W)
  ) u_alu (
    .a_i  (acc_q),
    .b_i  (mem_rdata),
    .fn_i (ctl.alu_fn),
    .y_o  (alu_y)
  );

  always_comb begin
    unique case (ctl.acc_src)
      ACC_MEM:  acc_d = mem_rdata;
      ACC_IMM:  acc_d = imm_nibble;
      ACC_ALU:  acc_d = alu_y;
      ACC_IN:   acc_d = in_port_i;
      ACC_BYTE: acc_d = imm_byte;
      default:  acc_d = acc_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q      <= '0;
      out_q      <= '0;
      ldb_pend_q <= 1'b0;
    end else begin
      acc_q      <= acc_d;
      ldb_pend_q <= ctl.ldb_start;
      if (out_we) begin
        out_q <= acc_q;
      end
    end
  end

  assign imem_addr_o = pc;
  assign out_port_o  = out_q;

endmodule

// File: rtl/acc_core_checker.sv
module acc_core_checker #(
  parameter int DATA_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [6:0]        pc,
  input logic [7:0]        instr,
  input logic [DATA_W-1:0] acc,
  input logic [DATA_W-1:0] out_port,
  input logic [DATA_W-1:0] in_port,
  input logic              branch_taken,
  input logic              out_we,
  input logic              is_in,
  input logic              ldb_pend
);

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (pc == 7'd0 && acc == '0 && out_port == '0 && !ldb_pend));

  assert_pc_step_R2: assert property (@(posedge clk) disable iff (rst)
    !branch_taken |=> pc == 7'($past(pc) + 7'd1));

  assert_branch_target_R7: assert property (@(posedge clk) disable iff (rst)
    branch_taken |=> pc == $past(instr[6:0]));

  assert_branch_on_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (instr[7] && !ldb_pend && acc == '0) |-> branch_taken);

  assert_out_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !out_we |=> $stable(out_port));

  assert_out_load_R6: assert property (@(posedge clk) disable iff (rst)
    out_we |=> out_port == $past(acc));

  assert_in_load_R6: assert property (@(posedge clk) disable iff (rst)
    is_in |=> acc == $past(in_port));

  assert_byte_literal_R8: assert property (@(posedge clk) disable iff (rst)
    ldb_pend |=> (acc == $past(instr[DATA_W-1:0]) && !ldb_pend));

endmodule

bind acc_core acc_core_checker #(
  .DATA_W (DATA_W)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .pc           (imem_addr_o),
  .instr        (imem_data_i),
  .acc          (acc_q),
  .out_port     (out_port_o),
  .in_port      (in_port_i),
  .branch_taken (branch_taken),
  .out_we       (out_we),
  .is_in        (is_in),
  .ldb_pend     (ldb_pend_q)
);

// File: tb/acc_core_tb.sv
module acc_core_tb;

  localparam int CLK_PERIOD = 10;
  localparam int RUN_CYCLES = 4000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] in_val = 8'h00;
  logic [7:0] lfsr = 8'h5b;

  logic [7:0] rom4 [128];
  logic [7:0] rom8 [128];

  logic [6:0] pc4, pc8;
  logic [3:0] out4;
  logic [7:0] out8;

  int checks = 0;
  int fails  = 0;
  bit armed  = 1'b0;

  // reference state, index 0 = nibble variant, 1 = byte variant
  int    mpc   [2];
  int    macc  [2];
  int    mout  [2];
  bit    mpend [2];
  int    mmem  [2][8];
  string mtag  [2];
  int    wid   [2] = '{4, 8};
  int    dep   [2] = '{8, 4};

  always #(CLK_PERIOD/2) clk = ~clk;

  acc_core #(.DATA_W(4)) u_dut (
    .clk         (clk),
    .rst         (rst),
    .imem_addr_o (pc4),
    .imem_data_i (rom4[pc4]),
    .in_port_i   (in_val[3:0]),
    .out_port_o  (out4)
  );

  acc_core #(.DATA_W(8)) u_dut8 (
    .clk         (clk),
    .rst         (rst),
    .imem_addr_o (pc8),
    .imem_data_i (rom8[pc8]),
    .in_port_i   (in_val),
    .out_port_o  (out8)
  );

  function automatic int fetch(int v, int a);
    return (v == 0) ? int'(rom4[a]) : int'(rom8[a]);
  endfunction

  task automatic check(string tag, string what, int actual, int expected);
    checks++;
    if (actual != expected) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, actual, expected);
    end
  endtask

  task automatic step(int v);
    int mask, ins, npc, fld, a;
    mask = (1 << wid[v]) - 1;
    if (rst) begin
      mpc[v] = 0; macc[v] = 0; mout[v] = 0; mpend[v] = 0;
      mtag[v] = "R1";
      return;
    end
    ins = fetch(v, mpc[v]);
    npc = (mpc[v] + 1) % 128;
    fld = ins % 16;
    a   = fld % dep[v];
    mtag[v] = "R2";
    if (mpend[v]) begin
      macc[v] = ins & mask; mpend[v] = 0; mtag[v] = "R8";
    end else if (ins >= 128) begin
      mtag[v] = "R7";
      if (macc[v] == 0) npc = ins - 128;
    end else begin
      case (ins / 16)
        0: begin macc[v] = mmem[v][a]; mtag[v] = (fld >= dep[v]) ? "R9" : "R3"; end
        1: begin mmem[v][a] = macc[v]; mtag[v] = (fld >= dep[v]) ? "R9" : "R3"; end
        2: begin macc[v] = fld; mtag[v] = "R4"; end
        3: begin macc[v] = (macc[v] + mmem[v][a]) & mask; mtag[v] = "R5"; end
        4: begin macc[v] = mask - (macc[v] & mmem[v][a]); mtag[v] = "R5"; end
        5: begin macc[v] = (macc[v] ^ mmem[v][a]) & mask; mtag[v] = "R5"; end
        6: begin
          if (ins % 2 == 1) macc[v] = int'(in_val) & mask;
          else mout[v] = macc[v];
          mtag[v] = "R6";
        end
        default: begin
          if (wid[v] == 8) mpend[v] = 1;
          mtag[v] = "R8";
        end
      endcase
    end
    mpc[v] = npc;
  endtask

  always @(posedge clk) begin
    for (int v = 0; v < 2; v++) step(v);
    armed = 1'b1;
  end

  always @(negedge clk) begin
    if (armed) begin
      check(mtag[0], "nibble pc", int'(pc4), mpc[0]);
      check(mtag[0], "nibble out", int'(out4), mout[0]);
      check(mtag[1], "byte pc", int'(pc8), mpc[1]);
      check(mtag[1], "byte out", int'(out8), mout[1]);
    end
    lfsr   = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    in_val = (lfsr[2:0] == 3'd0) ? 8'h00 : lfsr;
  end

  int p;

  task automatic emit2(logic [7:0] b4, logic [7:0] b8);
    rom4[p] = b4;
    rom8[p] = b8;
    p++;
  endtask

  task automatic emit(logic [7:0] b);
    emit2(b, b);
  endtask

  task automatic load_program();
    logic [7:0] r;
    p = 0;
    emit(8'h82);                 // R7: zero accumulator after reset -> jump to 2
    emit(8'h60);
    for (int k = 0; k < 8; k++) begin
      emit(8'h20 | 8'(k));       // R4
      emit(8'h10 | 8'(k));       // R3 / R9 aliasing in byte variant
    end
    emit(8'h25); emit(8'h10); emit(8'h2C); emit(8'h30); emit(8'h60);  // R5 add wrap
    emit(8'h11); emit(8'h41); emit(8'h60);                             // R5 nand
    emit(8'h50); emit(8'h60);                                          // R5 xor
    emit(8'h61); emit(8'h60);                                          // R6 in
    emit(8'h80 | 8'(p + 3)); emit(8'h2F); emit(8'h60);                 // R7
    emit(8'h1C); emit(8'h00); emit(8'h60); emit(8'h04); emit(8'h60);  // R9
    emit(8'h20);
    emit2(8'h73, 8'h70);         // R8: no effect / byte load
    emit2(8'h60, 8'hA5);
    emit(8'h60);
    emit2(8'h29, 8'h70);
    emit2(8'h60, 8'h80);         // literal that looks like a branch
    emit(8'h60);
    r = 8'h3d;
    while (p < 128) begin
      r = {r[6:0], r[7] ^ r[5] ^ r[4] ^ r[3]};
      if (r[7] && r[6:0] == 7'(p)) emit(8'h60);
      else if (p % 3 == 0) emit(8'h60);
      else emit(r);
    end
  endtask

  initial begin
    load_program();
    fork
      begin
        repeat (3) @(negedge clk);
        check("R1", "reset pc nibble", int'(pc4), 0);
        check("R1", "reset out byte", int'(out8), 0);
        rst = 1'b0;
        wait (mpend[1] == 1'b1);
        @(negedge clk);
        rst = 1'b1;              // R1: reset cancels the pending literal
        @(negedge clk);
        check("R1", "mid reset pc byte", int'(pc8), 0);
        check("R1", "mid reset out nibble", int'(out4), 0);
        rst = 1'b0;
        repeat (RUN_CYCLES) @(negedge clk);
      end
      begin
        repeat (RUN_CYCLES * 4) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R2 watchdog expired actual=%0d expected=%0d", RUN_CYCLES * 4, RUN_CYCLES);
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule